// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of an N-bit successive-approximation analog-to-digital converter. A one-cycle start request in idle opens a conversion: the block spends one cycle commanding the external sample-and-hold to acquire the input. It then runs a binary search, one bit per clock, from the most significant bit down. Each cycle it drives a trial word to an external DAC and reads back a single comparator line. That line is high when the held input is above the DAC level.

The search result is presented as an offset-binary code together with a one-cycle done strobe. The result stays put until a later conversion completes. The analog parts (sample-and-hold, DAC, comparator) sit outside the block. A new start request may be given in the same cycle as the done strobe, so conversions can run back to back with no gap.

Top module: `sar_adc_ctrl`

## Requirements
- R1: A start request seen in idle makes the next cycle a sample cycle. In that cycle sample_en is 1, dac_code is 0 and busy is 1. busy stays 1 for exactly WIDTH+1 cycles in total (the sample cycle plus the decision cycles).
- R2: In the decision cycle for bit k, dac_code holds the bits already decided above k, a 1 at position k, and zeros below k. Bit k runs from WIDTH-1 down to 0, one step per cycle.
- R3: Bit k of the result is 1 when cmp_gt is 1 at the end of the decision cycle for bit k, and 0 otherwise.
- R4: After exactly WIDTH decision cycles the block returns to idle. Outside decision cycles dac_code is 0.
- R5: The result is offset-binary: code c stands for c - 2^(WIDTH-1). The comparator reports held input > (c - 2^(WIDTH-1) - 1/2) LSB. With such a comparator, an integer input v converts to v + 2^(WIDTH-1), clamped to the range 0 to 2^WIDTH-1. For WIDTH=2 the codes 00, 01, 10 and 11 stand for -2, -1, 0 and +1.
- R6: A start request in a sample or decision cycle has no effect on the conversion in progress or on its timing.
- R7: done is high for exactly one cycle, the cycle after the last decision. A start request in that cycle is accepted.
- R8: result changes only in the cycle where done is high, and holds its value otherwise.
- R9: A synchronous active-high reset returns the block to idle. It forces busy, sample_en, done, dac_code and result to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, honoured only in idle or in the done cycle |
| cmp_gt | input | 1 | Comparator decision: held input above DAC level |
| sample_en | output | 1 | Sample-and-hold acquire command, high during the sample cycle |
| busy | output | 1 | High during the sample and decision cycles |
| dac_code | output | WIDTH | Trial word for the external DAC |
| done | output | 1 | One-cycle strobe marking a new result |
| result | output | WIDTH | Last completed conversion, offset-binary |

## Verification
Two events can fall in the same cycle: the done strobe that publishes a result, and the acceptance of the next start request. The bench provokes this by raising start in exactly the cycle where it sees done. A cycle-accurate reference model then checks two things: the finished result appears and holds, and the new sample cycle follows at once with a cleared trial word. Start requests are also fired in the middle of a search, and the model confirms that the search continues and ends on its original schedule.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_DECIDE = 2'd2
  } sar_phase_e;
endpackage

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  output sar_phase_e               phase,
  output logic [$clog2(WIDTH)-1:0] bit_idx,
  output logic                     accept,
  output logic                     last_step
);
  localparam int IW = $clog2(WIDTH);
  localparam logic [IW-1:0] TOP_IDX = IW'(WIDTH - 1);

  assign accept    = start && (phase == PH_IDLE);
  assign last_step = (phase == PH_DECIDE) && (bit_idx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      bit_idx <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (accept) phase <= PH_SAMPLE;
        PH_SAMPLE: begin
          phase   <= PH_DECIDE;
          bit_idx <= TOP_IDX;
        end
        PH_DECIDE: begin
          if (last_step) phase <= PH_IDLE;
          else bit_idx <= bit_idx - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  a_r1_start_to_sample: assert property (@(posedge clk) disable iff (rst)
    accept |=> (phase == PH_SAMPLE));
  a_r2_first_bit_msb: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SAMPLE) |=> (phase == PH_DECIDE && bit_idx == TOP_IDX));
  a_r4_index_descends: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DECIDE && !last_step) |=>
      (phase == PH_DECIDE && bit_idx == $past(bit_idx) - 1'b1));
  a_r4_end_to_idle: assert property (@(posedge clk) disable iff (rst)
    last_step |=> (phase == PH_IDLE));
  a_r6_start_ignored_in_sample: assert property (@(posedge clk) disable iff (rst)
    (start && phase == PH_SAMPLE) |=> (phase == PH_DECIDE));
endmodule

// File: rtl/sar_word.sv
module sar_word
  import sar_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  sar_phase_e               phase,
  input  logic [$clog2(WIDTH)-1:0] bit_idx,
  input  logic                     cmp_gt,
  output logic [WIDTH-1:0]         dac_code,
  output logic [WIDTH-1:0]         final_word
);
  localparam int IW = $clog2(WIDTH);

  function automatic logic [WIDTH-1:0] bit_mask(input logic [IW-1:0] idx);
    logic [WIDTH-1:0] m;
    m = '0;
    m[idx] = 1'b1;
    return m;
  endfunction

  function automatic logic [WIDTH-1:0] at_or_below(input logic [IW-1:0] idx);
    logic [WIDTH:0] t;
    t = {1'b0, bit_mask(idx)} << 1;
    return WIDTH'(t - 1'b1);
  endfunction

  function automatic logic [WIDTH-1:0] commit(input logic [WIDTH-1:0] w,
                                              input logic [IW-1:0]    idx,
                                              input logic             keep);
    return keep ? (w | bit_mask(idx)) : w;
  endfunction

  logic [WIDTH-1:0] decided;

  always_ff @(posedge clk) begin
    if (rst) decided <= '0;
    else if (phase == PH_SAMPLE) decided <= '0;
    else if (phase == PH_DECIDE) decided <= commit(decided, bit_idx, cmp_gt);
  end

  assign dac_code   = (phase == PH_DECIDE) ? (decided | bit_mask(bit_idx)) : '0;
  assign final_word = commit(decided, bit_idx, cmp_gt);

  a_r2_low_bits_clear: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DECIDE) |-> ((decided & at_or_below(bit_idx)) == '0));
  a_r3_bit_follows_cmp: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DECIDE) |=> (decided[$past(bit_idx)] == $past(cmp_gt)));
  a_r4_dac_quiet: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_DECIDE) |-> (dac_code == '0));
endmodule

// File: rtl/sar_out.sv
module sar_out #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             last_step,
  input  logic [WIDTH-1:0] final_word,
  output logic [WIDTH-1:0] result,
  output logic             done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= last_step;
      if (last_step) result <= final_word;
    end
  end

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_result_held: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cmp_gt,
  output logic             sample_en,
  output logic             busy,
  output logic [WIDTH-1:0] dac_code,
  output logic             done,
  output logic [WIDTH-1:0] result
);
  localparam int IW = $clog2(WIDTH);

  sar_phase_e       phase;
  logic [IW-1:0]    bit_idx;
  logic             accept;
  logic             last_step;
  logic [WIDTH-1:0] final_word;

  sar_seq #(.WIDTH(WIDTH)) u_seq (
    .clk(clk), .rst(rst), .start(start), .phase(phase),
    .bit_idx(bit_idx), .accept(accept), .last_step(last_step)
  );

  sar_word #(.WIDTH(WIDTH)) u_word (
    .clk(clk), .rst(rst), .phase(phase), .bit_idx(bit_idx),
    .cmp_gt(cmp_gt), .dac_code(dac_code), .final_word(final_word)
  );

  sar_out #(.WIDTH(WIDTH)) u_out (
    .clk(clk), .rst(rst), .last_step(last_step),
    .final_word(final_word), .result(result), .done(done)
  );

  assign busy      = (phase != PH_IDLE);
  assign sample_en = (phase == PH_SAMPLE);

  a_r1_sample_quiet_dac: assert property (@(posedge clk) disable iff (rst)
    sample_en |-> (busy && dac_code == '0));
  a_r7_done_when_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!busy && !done && result == '0));
endmodule

// File: tb/tb_sar_adc_ctrl.sv
`timescale 1ns/1ps
module tb_sar_adc_ctrl;
  localparam int N = 8;
  localparam int H = 1 << (N - 1);
  localparam int MAXC = (1 << N) - 1;

  logic clk = 1'b0;
  logic rst, start;
  logic sample_en, busy, done;
  logic [N-1:0] dac_code, result;
  int ain = 0;
  int held = 0;
  logic cmp_gt;

  // R5: ideal comparator, threshold half an LSB below the DAC level
  assign cmp_gt = (2 * held) > (2 * (int'(dac_code) - H) - 1);

  sar_adc_ctrl #(.WIDTH(N)) dut (
    .clk(clk), .rst(rst), .start(start), .cmp_gt(cmp_gt),
    .sample_en(sample_en), .busy(busy), .dac_code(dac_code),
    .done(done), .result(result)
  );

  always #2.5 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;

  // reference model: 0 idle, 1 sample, 2 decide
  int m_phase = 0, m_idx = 0, m_word = 0, m_result = 0, m_busy_len = 0;
  bit m_done = 0;

  function automatic int m_dac();
    return (m_phase == 2) ? (m_word | (1 << m_idx)) : 0;
  endfunction

  function automatic int expect_code(int v);
    int c = v + H;
    if (c < 0) c = 0;
    if (c > MAXC) c = MAXC;
    return c;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_idx = 0; m_word = 0; m_result = 0; m_done = 0;
    end else begin
      bit mc;
      mc = (2 * held) > (2 * (m_dac() - H) - 1);
      m_done = 0;
      case (m_phase)
        0: if (start) m_phase = 1;
        1: begin m_phase = 2; m_idx = N - 1; m_word = 0; end
        default: begin
          if (mc) m_word = m_word | (1 << m_idx);
          if (m_idx == 0) begin
            m_result = m_word; m_done = 1; m_phase = 0;
          end else m_idx = m_idx - 1;
        end
      endcase
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  bit cmp_on = 0;
  always @(negedge clk) begin
    if (sample_en) held = ain;
    if (cmp_on) begin
      chk("R1", "sample_en", int'(sample_en), int'(m_phase == 1));
      chk("R4", "busy", int'(busy), int'(m_phase != 0));
      chk("R2", "dac_code", int'(dac_code), m_dac());
      chk("R7", "done", int'(done), int'(m_done));
      chk("R8", "result", int'(result), m_result);
      if (busy) m_busy_len++;
      if (done) begin
        chk("R1", "busy span", m_busy_len, N + 1);
        m_busy_len = 0;
      end
      if (!busy && !done) m_busy_len = 0;
    end
  end

  task automatic wait_done();
    for (int i = 0; i < 4 * N; i++) begin
      @(negedge clk);
      if (done) return;
    end
    chk("R7", "done missing", 0, 1);
  endtask

  task automatic convert(int v);
    ain = v;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done();
    chk("R5", "code", int'(result), expect_code(v));
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 50000) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; start = 1'b0;
    cmp_on = 1;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "reset busy", int'(busy), 0);
    chk("R9", "reset result", int'(result), 0);
    chk("R9", "reset dac", int'(dac_code), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R3 R5: value sweep including extremes and clamping
    convert(-128); convert(127); convert(0); convert(-1); convert(1);
    convert(-64);  convert(63);  convert(37); convert(-99);
    convert(300);  convert(-500);

    // R6: start pulses during sample and decision cycles
    ain = 22;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b1;          // lands in sample cycle
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1;                           // in decision cycles
    @(negedge clk); start = 1'b0;
    wait_done();
    chk("R6", "code after ignored starts", int'(result), expect_code(22));
    @(negedge clk);
    chk("R6", "idle after ignored starts", int'(busy), 0);

    // R7: start in the done cycle, back to back
    ain = -45;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done();
    chk("R5", "first of pair", int'(result), expect_code(-45));
    ain = 90; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R7", "sample right after done", int'(sample_en), 1);
    chk("R8", "result held after done", int'(result), expect_code(-45));
    wait_done();
    chk("R5", "second of pair", int'(result), expect_code(90));

    // R9: reset during a conversion
    ain = 11;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9", "busy in reset", int'(busy), 0);
    chk("R9", "result in reset", int'(result), 0);
    rst = 1'b0;
    convert(5);
    repeat (3) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule